// File: doc/BRIEF.md
# Rename-Stage Move Elimination Unit

This block sits in the rename stage and decides, for each register-to-register move offered in a cycle, whether the move can be dropped. A dropped move gets no physical register. Its destination points at the source's current definition instead. Each logical register belongs to one register file, and the files are equal, contiguous slices of the logical ID space: file = ID / (NREG/NFILE).

Each file has three settings:
- a limit on eliminations per cycle, where a limit of 0 means unlimited;
- an optional policy that allows only moves whose source is known to hold zero;
- a mask that marks which destinations may be eliminated at all.

The unit keeps a bitmap with one bit per logical register that is known to contain zero. It learns this bitmap from zero-idiom writes, from ordinary writes and from the moves themselves.

All decisions are combinational within the request cycle. The per-file counters and the zero bitmap update at the next rising clock edge. A `cyc_start` pulse marks the first cycle of a new machine cycle. In that cycle the counters read as zero for the requests presented with it.

Top module: `move_elim_unit`

## Requirements
- R1: After reset the zero bitmap is all clear and every counter is zero. A move whose source has seen no zero-idiom write is therefore reported with `wzero` = 0.
- R2: A move is eliminated only if its destination bit in `ELIG` is 1. With the defaults, registers 7 and 15 are ineligible.
- R3: A move whose source and destination lie in different files is never eliminated. With the defaults, file 0 is IDs 0..7 and file 1 is IDs 8..15.
- R4: In one cycle, the requests of a file are granted in slot order, lowest slot first, until its limit is reached. Later slots of that file are rejected. The default limit is 2 for file 0.
- R5: The count of eliminations carries across cycles and clears only with `cyc_start`. Requests presented together with `cyc_start` see a count of zero.
- R6: A file with limit 0 grants any number of eliminations per cycle and across cycles. File 1 is such a file by default.
- R7: In a file with the zero-only policy, a move is eliminated only if its source bit is set in the bitmap. File 1 has this policy by default.
- R8: For an eliminated slot, `alias_id` equals the source ID and `wzero` equals the source's zero bit. For any other slot, both outputs are 0.
- R9: At the next clock edge the bitmap is updated in this order, each step overriding the one before:
  - an ordinary write clears its bit;
  - a zero-idiom write sets its bit;
  - each valid move, in slot order, writes its destination: an eliminated move copies the source bit, a rejected move clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | First cycle of a new machine cycle; clears the elimination counts |
| mv_valid | input | NSLOT | Move request valid, one bit per slot |
| mv_src | input | NSLOT*IDW | Source logical ID; slot s occupies bits [s*IDW +: IDW] |
| mv_dst | input | NSLOT*IDW | Destination logical ID, packed the same way |
| zw_valid | input | 1 | Zero-idiom write valid |
| zw_id | input | IDW | Destination of the zero-idiom write |
| ow_valid | input | 1 | Ordinary write valid |
| ow_id | input | IDW | Destination of the ordinary write |
| elim | output | NSLOT | Move eliminated, per slot |
| wzero | output | NSLOT | Eliminated move writes zero; no physical register needed |
| alias_id | output | NSLOT*IDW | Source ID that the destination aliases, per slot |

## Verification
The checker examines every cycle for the following:
- a rejected slot drives nothing on its outputs;
- no grant goes to an ineligible destination or across files;
- every grant in a zero-only file reports writes-zero;
- the grants of a limited file, summed since the last `cyc_start` in a counter kept by the checker, never exceed the limit.

Some behaviours appear only in the bench scenarios:
- slot-order priority;
- unlimited granting;
- the ordering of bitmap updates, including a rejected move clearing its destination.

The bench makes the bitmap visible by offering later moves and watching `wzero` and `elim`.

// File: rtl/move_elim_unit.sv
module move_elim_unit #(
  parameter int NREG  = 16,
  parameter int NFILE = 2,
  parameter int NSLOT = 3,
  parameter int CW    = 4,
  parameter logic [NFILE*CW-1:0] MAX_ELIM  = 8'h02,
  parameter logic [NFILE-1:0]    ZERO_ONLY = 2'b10,
  parameter logic [NREG-1:0]     ELIG      = 16'h7F7F,
  localparam int IDW = $clog2(NREG),
  localparam int RPF = NREG / NFILE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cyc_start,
  input  logic [NSLOT-1:0]     mv_valid,
  input  logic [NSLOT*IDW-1:0] mv_src,
  input  logic [NSLOT*IDW-1:0] mv_dst,
  input  logic                 zw_valid,
  input  logic [IDW-1:0]       zw_id,
  input  logic                 ow_valid,
  input  logic [IDW-1:0]       ow_id,
  output logic [NSLOT-1:0]     elim,
  output logic [NSLOT-1:0]     wzero,
  output logic [NSLOT*IDW-1:0] alias_id
);

  function automatic int file_of(input logic [IDW-1:0] id);
    return int'(id) / RPF;
  endfunction

  logic [CW-1:0] cnt_q [NFILE];
  logic [CW-1:0] run   [NFILE];
  logic [NREG-1:0] zmap_q, zmap_n;

  always_comb begin
    for (int f = 0; f < NFILE; f++)
      run[f] = cyc_start ? '0 : cnt_q[f];
    elim     = '0;
    wzero    = '0;
    alias_id = '0;
    for (int s = 0; s < NSLOT; s++) begin
      logic [IDW-1:0] src, dst;
      logic [CW-1:0]  lim;
      int fs;
      src = mv_src[s*IDW +: IDW];
      dst = mv_dst[s*IDW +: IDW];
      fs  = file_of(src);
      lim = MAX_ELIM[fs*CW +: CW];
      if (mv_valid[s] && ELIG[dst] && fs == file_of(dst) &&
          (!ZERO_ONLY[fs] || zmap_q[src]) &&
          (lim == '0 || run[fs] < lim)) begin
        elim[s] = 1'b1;
        wzero[s] = zmap_q[src];
        alias_id[s*IDW +: IDW] = src;
        if (run[fs] != '1)
          run[fs] = run[fs] + {{(CW-1){1'b0}}, 1'b1};
      end
    end
  end

  always_comb begin
    zmap_n = zmap_q;
    if (ow_valid) zmap_n[ow_id] = 1'b0;
    if (zw_valid) zmap_n[zw_id] = 1'b1;
    for (int s = 0; s < NSLOT; s++)
      if (mv_valid[s])
        zmap_n[mv_dst[s*IDW +: IDW]] = elim[s] & zmap_q[mv_src[s*IDW +: IDW]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zmap_q <= '0;
      for (int f = 0; f < NFILE; f++) cnt_q[f] <= '0;
    end else begin
      zmap_q <= zmap_n;
      for (int f = 0; f < NFILE; f++) cnt_q[f] <= run[f];
    end
  end

endmodule

// File: rtl/move_elim_chk.sv
module move_elim_chk #(
  parameter int NREG  = 16,
  parameter int NFILE = 2,
  parameter int NSLOT = 3,
  parameter int CW    = 4,
  parameter logic [NFILE*CW-1:0] MAX_ELIM  = 8'h02,
  parameter logic [NFILE-1:0]    ZERO_ONLY = 2'b10,
  parameter logic [NREG-1:0]     ELIG      = 16'h7F7F,
  localparam int IDW = $clog2(NREG),
  localparam int RPF = NREG / NFILE
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cyc_start,
  input logic [NSLOT-1:0]     mv_valid,
  input logic [NSLOT*IDW-1:0] mv_src,
  input logic [NSLOT*IDW-1:0] mv_dst,
  input logic [NSLOT-1:0]     elim,
  input logic [NSLOT-1:0]     wzero,
  input logic [NSLOT*IDW-1:0] alias_id
);

  function automatic int fl(input logic [IDW-1:0] id);
    return int'(id) / RPF;
  endfunction

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !elim[s] |-> (!wzero[s] && alias_id[s*IDW +: IDW] == '0));
    // R2
    elig_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elim[s] |-> (mv_valid[s] && ELIG[mv_dst[s*IDW +: IDW]]));
    // R3
    same_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elim[s] |-> (fl(mv_src[s*IDW +: IDW]) == fl(mv_dst[s*IDW +: IDW])));
    // R7
    zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (elim[s] && ZERO_ONLY[fl(mv_src[s*IDW +: IDW])]) |-> wzero[s]);
  end

  for (genvar f = 0; f < NFILE; f++) begin : g_file
    localparam int LIM = int'(MAX_ELIM[f*CW +: CW]);
    if (LIM != 0) begin : g_lim
      logic [15:0] seen_q;
      int now, eff;
      always_comb begin
        now = 0;
        for (int s = 0; s < NSLOT; s++)
          if (elim[s] && fl(mv_src[s*IDW +: IDW]) == f) now++;
        eff = cyc_start ? 0 : int'(seen_q);
      end
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) seen_q <= '0;
        else seen_q <= 16'(eff + now);
      // R4 R5
      rate_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff + now) <= LIM);
    end
  end

endmodule

bind move_elim_unit move_elim_chk #(
  .NREG(NREG), .NFILE(NFILE), .NSLOT(NSLOT), .CW(CW),
  .MAX_ELIM(MAX_ELIM), .ZERO_ONLY(ZERO_ONLY), .ELIG(ELIG)
) i_move_elim_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .mv_valid(mv_valid),
  .mv_src(mv_src), .mv_dst(mv_dst), .elim(elim), .wzero(wzero),
  .alias_id(alias_id)
);

// File: tb/test_move_elim_unit.sv
module test_move_elim_unit;
  localparam int IDW = 4;
  localparam int NSLOT = 3;

  logic clk = 1'b0, rst_n = 1'b0, cyc_start = 1'b0;
  logic [NSLOT-1:0] mv_valid = '0;
  logic [NSLOT*IDW-1:0] mv_src = '0, mv_dst = '0;
  logic zw_valid = 1'b0, ow_valid = 1'b0;
  logic [IDW-1:0] zw_id = '0, ow_id = '0;
  logic [NSLOT-1:0] elim, wzero;
  logic [NSLOT*IDW-1:0] alias_id;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  move_elim_unit i_move_elim_unit (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .mv_valid(mv_valid),
    .mv_src(mv_src), .mv_dst(mv_dst), .zw_valid(zw_valid), .zw_id(zw_id),
    .ow_valid(ow_valid), .ow_id(ow_id), .elim(elim), .wzero(wzero),
    .alias_id(alias_id));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic begin_cycle(input bit cs);
    @(negedge clk);
    cyc_start = cs; mv_valid = '0; mv_src = '0; mv_dst = '0;
    zw_valid = 1'b0; ow_valid = 1'b0;
  endtask

  task automatic put(input int s, input int src, input int dst);
    mv_valid[s] = 1'b1;
    mv_src[s*IDW +: IDW] = IDW'(src);
    mv_dst[s*IDW +: IDW] = IDW'(dst);
  endtask

  task automatic expect_slot(input string req, input int s, input int e,
                             input int z, input int a);
    #1;
    chk({req, " elim"}, int'(elim[s]), e);
    chk({req, " wzero"}, int'(wzero[s]), z);
    chk({req, " alias"}, int'(alias_id[s*IDW +: IDW]), a);
  endtask

  task automatic t_reset;
    begin_cycle(1'b1);
    put(0, 9, 14); put(1, 2, 6);
    expect_slot("R1 zero-only src clear", 0, 0, 0, 0);
    expect_slot("R1 wzero clear", 1, 1, 0, 2);
  endtask

  task automatic t_elig;
    begin_cycle(1'b1);
    put(0, 1, 7); put(1, 3, 5);
    expect_slot("R2 ineligible", 0, 0, 0, 0);
    expect_slot("R2 eligible", 1, 1, 0, 3);
  endtask

  task automatic t_cross;
    begin_cycle(1'b1);
    put(0, 2, 9);
    expect_slot("R3 cross file", 0, 0, 0, 0);
  endtask

  task automatic t_limit;
    begin_cycle(1'b1);
    put(0, 1, 2); put(1, 3, 4); put(2, 5, 6);
    expect_slot("R4 slot0", 0, 1, 0, 1);
    expect_slot("R4 slot1", 1, 1, 0, 3);
    expect_slot("R4 slot2 over limit", 2, 0, 0, 0);
  endtask

  task automatic t_carry;
    begin_cycle(1'b1); put(0, 1, 2);
    expect_slot("R5 first", 0, 1, 0, 1);
    begin_cycle(1'b0); put(0, 3, 4); put(1, 5, 3);
    expect_slot("R5 carried one left", 0, 1, 0, 3);
    expect_slot("R5 carried exhausted", 1, 0, 0, 0);
    begin_cycle(1'b0); put(0, 1, 2);
    expect_slot("R5 still exhausted", 0, 0, 0, 0);
    begin_cycle(1'b1); put(0, 1, 2); put(1, 3, 4);
    expect_slot("R5 cleared slot0", 0, 1, 0, 1);
    expect_slot("R5 cleared slot1", 1, 1, 0, 3);
  endtask

  task automatic t_zero_only;
    begin_cycle(1'b1); zw_valid = 1'b1; zw_id = 4'd8;
    begin_cycle(1'b1); put(0, 10, 9); put(1, 8, 11);
    expect_slot("R7 nonzero src", 0, 0, 0, 0);
    expect_slot("R7 R8 zero src", 1, 1, 1, 8);
  endtask

  task automatic t_unlimited;
    begin_cycle(1'b1); put(0, 8, 12); put(1, 11, 13); put(2, 8, 10);
    expect_slot("R6 s0", 0, 1, 1, 8);
    expect_slot("R6 s1", 1, 1, 1, 11);
    expect_slot("R6 s2", 2, 1, 1, 8);
    begin_cycle(1'b0); put(0, 12, 9); put(1, 13, 14); put(2, 10, 11);
    expect_slot("R6 R9 next s0", 0, 1, 1, 12);
    expect_slot("R6 R9 next s1", 1, 1, 1, 13);
    expect_slot("R6 R9 next s2", 2, 1, 1, 10);
  endtask

  task automatic t_clear;
    begin_cycle(1'b1); ow_valid = 1'b1; ow_id = 4'd12;
    zw_valid = 1'b1; zw_id = 4'd3;
    begin_cycle(1'b1); put(0, 12, 9); put(1, 3, 5);
    expect_slot("R9 ordinary write cleared", 0, 0, 0, 0);
    expect_slot("R9 zero idiom set", 1, 1, 1, 3);
    begin_cycle(1'b1); put(0, 9, 10);
    expect_slot("R9 rejected move cleared dst", 0, 0, 0, 0);
    begin_cycle(1'b1); ow_valid = 1'b1; ow_id = 4'd13;
    zw_valid = 1'b1; zw_id = 4'd13;
    begin_cycle(1'b1); put(0, 13, 14);
    expect_slot("R9 zero idiom over ordinary", 0, 1, 1, 13);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset; t_elig; t_cross; t_limit; t_carry;
    t_zero_only; t_unlimited; t_clear;
    begin_cycle(1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule